// File: doc/BRIEF.md
# MSI Message Decoder with Partition-Endpoint Ownership Check

This block sits at the front of a message-signalled interrupt path. It takes two kinds of event and reduces each to a source number. The first is a message write, which carries an address, 16 bits of data and, optionally, the partition-endpoint (PE) number of the requester. The second is a write to the fixed-function interrupt register, which carries a single value. For every accepted event the block emits exactly one outcome pulse: a trigger for the source, an out-of-bounds error or a PE-mismatch error. A downstream stage turns triggers into presented interrupts.

The source number combines two fields by OR: address bits 19..4 with data bits 4..0. The source is checked against a configured source count. When a requester PE is attached, the block reads that source's table entry through a request/acknowledge port and compares the PE field it returns. The configured base offset is added to the source to give the global interrupt number that goes with each trigger. While a decision is pending, both inputs are held off through their ready signals.

The controller is a three-state machine. `ST_IDLE` accepts an event and moves to `ST_CHECK`. `ST_CHECK` can return to `ST_IDLE` on an out-of-bounds drop or on a trigger without a PE. Otherwise it moves to `ST_FETCH` to read the entry. `ST_FETCH` holds the entry request until the acknowledge arrives, then emits a trigger or a mismatch error and returns to `ST_IDLE`.

Top module: `msi_decoder`

## Requirements
- R1: After reset, msg_ready and ffi_ready are 1, ffi_lock is 0, no outcome pulse is active, and the effective source count is 0, so every event is out of bounds.
- R2: The source number is (address bits 19..4) OR (data bits 4..0); data bits 15..5 have no effect. trig_src carries the source and trig_num carries base + source (BASE_W bits).
- R3: A source greater than or equal to the effective count produces one err_oob pulse, no trigger and no entry read, whether or not a PE is attached.
- R4: A configuration write loads the base and the count, and the count is clamped to MAX_SRC (2048). With a requested count of 4000, source 2047 triggers and source 2048 is out of bounds.
- R5: An in-range event without a PE triggers in the cycle after acceptance, with no entry read.
- R6: An in-range event with a PE raises ent_req with ent_idx equal to the source, holds it until ent_ack, and triggers in the ack cycle if ent_pe equals the requester PE.
- R7: If ent_pe differs from the requester PE, one err_pe pulse is emitted and there is no trigger.
- R8: msg_ready and ffi_ready are 0 from the cycle after acceptance until the outcome cycle, and are 1 again in the cycle after it.
- R9: A fixed-function write is treated as a message with the written value as the address, data 0 and no PE. ffi_lock goes to 1 on acceptance and is cleared to 0 when that event's outcome is emitted.
- R10: When a fixed-function write and a message are presented together in ST_IDLE, the fixed-function write is taken first: msg_ready is 0 while ffi_wr is 1.
- R11: Each accepted event produces exactly one one-cycle pulse on exactly one of trig_valid, err_oob and err_pe, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load base and count |
| cfg_base | input | BASE_W | Base offset of the source range |
| cfg_count | input | CNT_IN_W | Requested source count (clamped) |
| msg_valid | input | 1 | Message write present |
| msg_ready | output | 1 | Message write accepted when valid |
| msg_addr | input | ADDR_W | Message address |
| msg_data | input | 16 | Message data |
| msg_pe_vld | input | 1 | A requester PE is attached |
| msg_pe | input | PE_W | Requester PE number |
| ffi_wr | input | 1 | Fixed-function interrupt register write |
| ffi_ready | output | 1 | Fixed-function write accepted when asserted |
| ffi_val | input | ADDR_W | Written value, used as the address |
| ffi_lock | output | 1 | Fixed-function lock register |
| ent_req | output | 1 | Entry read request |
| ent_idx | output | SRC_W | Source whose entry is read |
| ent_ack | input | 1 | Entry read data valid |
| ent_pe | input | PE_W | PE field of the entry |
| trig_valid | output | 1 | One-cycle trigger |
| trig_src | output | SRC_W | Triggered source number |
| trig_num | output | BASE_W | Base plus source |
| err_oob | output | 1 | Out-of-bounds drop pulse |
| err_pe | output | 1 | PE-mismatch drop pulse |

## Verification
The hardest case to reach is the collision in ST_IDLE, where a fixed-function write and a message wait on the same edge. If ordering is wrong there, the outcomes come out swapped without any pulse going missing. The bench drives both requests in the same cycle and expects the fixed-function outcome to be popped from the scoreboard first. It also checks that the lock clears only after that outcome. The entry responder waits two cycles before it acknowledges, so back-pressure is observed while ST_FETCH is waiting. PE values come from a fixed function of the index, so both matching and mismatching requesters can be built.

// File: rtl/msi_dec_pkg.sv
package msi_dec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FETCH = 2'd2
    } msi_st_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs #(
    parameter int CNT_IN_W = 16,
    parameter int CNT_W    = 12,
    parameter int MAX_SRC  = 2048,
    parameter int BASE_W   = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [BASE_W-1:0]   cfg_base,
    input  logic [CNT_IN_W-1:0] cfg_count,
    output logic [BASE_W-1:0]   base_q,
    output logic [CNT_W-1:0]    cnt_q
);
    localparam logic [CNT_IN_W-1:0] LIMIT = CNT_IN_W'(MAX_SRC);

    logic [CNT_W-1:0] cnt_clamped;

    always_comb begin
        if (cfg_count > LIMIT) cnt_clamped = CNT_W'(MAX_SRC);
        else                   cnt_clamped = CNT_W'(cfg_count);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (cfg_wr) begin
            base_q <= cfg_base;
            cnt_q  <= cnt_clamped;
        end
    end
endmodule

// File: rtl/msi_src_derive.sv
module msi_src_derive #(
    parameter int ADDR_W = 32,
    parameter int SRC_W  = 16,
    parameter int LOW_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       data,
    output logic [SRC_W-1:0]  src
);
    localparam int SHIFT = 4;
    always_comb src = addr[SHIFT +: SRC_W] | SRC_W'(data[LOW_W-1:0]);
endmodule

// File: rtl/msi_bounds.sv
module msi_bounds #(
    parameter int SRC_W = 16,
    parameter int CNT_W = 12
) (
    input  logic [SRC_W-1:0] src,
    input  logic [CNT_W-1:0] cnt,
    output logic             in_range
);
    localparam int CMP_W = (SRC_W > CNT_W) ? SRC_W : CNT_W;
    always_comb in_range = CMP_W'(src) < CMP_W'(cnt);
endmodule

// File: rtl/msi_decoder.sv
module msi_decoder
    import msi_dec_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SRC_W    = 16,
    parameter int PE_W     = 8,
    parameter int BASE_W   = 20,
    parameter int CNT_IN_W = 16,
    parameter int MAX_SRC  = 2048
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [BASE_W-1:0]   cfg_base,
    input  logic [CNT_IN_W-1:0] cfg_count,
    input  logic                msg_valid,
    output logic                msg_ready,
    input  logic [ADDR_W-1:0]   msg_addr,
    input  logic [15:0]         msg_data,
    input  logic                msg_pe_vld,
    input  logic [PE_W-1:0]     msg_pe,
    input  logic                ffi_wr,
    output logic                ffi_ready,
    input  logic [ADDR_W-1:0]   ffi_val,
    output logic                ffi_lock,
    output logic                ent_req,
    output logic [SRC_W-1:0]    ent_idx,
    input  logic                ent_ack,
    input  logic [PE_W-1:0]     ent_pe,
    output logic                trig_valid,
    output logic [SRC_W-1:0]    trig_src,
    output logic [BASE_W-1:0]   trig_num,
    output logic                err_oob,
    output logic                err_pe
);
    localparam int CNT_W = $clog2(MAX_SRC + 1);

    msi_st_e            st_q, st_d;
    logic [BASE_W-1:0]  base_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [SRC_W-1:0]   src_in, src_q;
    logic [PE_W-1:0]    pe_q;
    logic               pe_vld_q, ffi_q, lock_q;
    logic               in_range, take_ffi, take_msg, accept, done;
    logic [ADDR_W-1:0]  sel_addr;
    logic [15:0]        sel_data;

    msi_cfg_regs #(
        .CNT_IN_W(CNT_IN_W), .CNT_W(CNT_W), .MAX_SRC(MAX_SRC), .BASE_W(BASE_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_base(cfg_base),
        .cfg_count(cfg_count), .base_q(base_q), .cnt_q(cnt_q)
    );

    // A fixed-function write wins the input mux and is taken with data 0.
    always_comb begin
        take_ffi = (st_q == ST_IDLE) && ffi_wr;
        take_msg = (st_q == ST_IDLE) && !ffi_wr && msg_valid;
        accept   = take_ffi || take_msg;
        sel_addr = take_ffi ? ffi_val : msg_addr;
        sel_data = take_ffi ? 16'h0000 : msg_data;
    end

    msi_src_derive #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_derive (
        .addr(sel_addr), .data(sel_data), .src(src_in)
    );

    msi_bounds #(.SRC_W(SRC_W), .CNT_W(CNT_W)) u_bounds (
        .src(src_q), .cnt(cnt_q), .in_range(in_range)
    );

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (accept) st_d = ST_CHECK;
            ST_CHECK: st_d = (in_range && pe_vld_q) ? ST_FETCH : ST_IDLE;
            ST_FETCH: if (ent_ack) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register and the request captured on acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            src_q    <= '0;
            pe_q     <= '0;
            pe_vld_q <= 1'b0;
            ffi_q    <= 1'b0;
            lock_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                src_q    <= src_in;
                pe_q     <= msg_pe;
                pe_vld_q <= take_msg && msg_pe_vld;
                ffi_q    <= take_ffi;
            end
            if (take_ffi)            lock_q <= 1'b1;
            else if (done && ffi_q)  lock_q <= 1'b0;
        end
    end

    // Outputs.
    always_comb begin
        msg_ready  = (st_q == ST_IDLE) && !ffi_wr;
        ffi_ready  = (st_q == ST_IDLE);
        ent_req    = 1'b0;
        trig_valid = 1'b0;
        err_oob    = 1'b0;
        err_pe     = 1'b0;
        done       = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_CHECK: begin
                err_oob    = !in_range;
                trig_valid = in_range && !pe_vld_q;
                done       = !in_range || !pe_vld_q;
            end
            ST_FETCH: begin
                ent_req    = 1'b1;
                trig_valid = ent_ack && (ent_pe == pe_q);
                err_pe     = ent_ack && (ent_pe != pe_q);
                done       = ent_ack;
            end
            default: ;
        endcase
        ent_idx  = src_q;
        trig_src = src_q;
        trig_num = base_q + BASE_W'(src_q);
        ffi_lock = lock_q;
    end
endmodule

// File: rtl/msi_decoder_chk.sv
module msi_decoder_chk #(
    parameter int SRC_W   = 16,
    parameter int CNT_W   = 12,
    parameter int MAX_SRC = 2048
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_valid,
    input logic             err_oob,
    input logic             err_pe,
    input logic             ent_req,
    input logic             ent_ack,
    input logic             msg_ready,
    input logic             ffi_ready,
    input logic             ffi_lock,
    input logic [SRC_W-1:0] trig_src,
    input logic [CNT_W-1:0] cnt_q
);
    localparam int W = SRC_W + CNT_W;

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trig_valid, err_oob, err_pe}));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |=> !trig_valid);

    assert_trig_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> (W'(trig_src) < W'(cnt_q)));

    assert_count_clamped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        W'(cnt_q) <= W'(MAX_SRC));

    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_req && !ent_ack) |=> ent_req);

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req |-> (!msg_ready && !ffi_ready));

    assert_lock_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ffi_lock) |-> $past(trig_valid || err_oob || err_pe));
endmodule

bind msi_decoder msi_decoder_chk #(
    .SRC_W(SRC_W), .CNT_W(CNT_W), .MAX_SRC(MAX_SRC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .err_oob(err_oob),
    .err_pe(err_pe), .ent_req(ent_req), .ent_ack(ent_ack),
    .msg_ready(msg_ready), .ffi_ready(ffi_ready), .ffi_lock(ffi_lock),
    .trig_src(trig_src), .cnt_q(cnt_q)
);

// File: tb/msi_decoder_bench.sv
module msi_decoder_bench;
    typedef struct {
        int kind;   // 0 trigger, 1 out of bounds, 2 PE mismatch
        int src;
        int num;
    } exp_t;

    logic        clk = 0, rst_n = 0;
    logic        cfg_wr = 0;
    logic [19:0] cfg_base = '0;
    logic [15:0] cfg_count = '0;
    logic        msg_valid = 0, msg_pe_vld = 0;
    logic [31:0] msg_addr = '0, ffi_val = '0;
    logic [15:0] msg_data = '0;
    logic [7:0]  msg_pe = '0, ent_pe = '0;
    logic        ffi_wr = 0, ent_ack = 0;
    logic        msg_ready, ffi_ready, ffi_lock, ent_req;
    logic [15:0] ent_idx, trig_src;
    logic [19:0] trig_num;
    logic        trig_valid, err_oob, err_pe;

    int checks = 0, failures = 0, acks = 0;
    int base_m = 0, cnt_m = 0;
    bit done_flag = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    msi_decoder u_msi_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_base(cfg_base),
        .cfg_count(cfg_count), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data), .msg_pe_vld(msg_pe_vld),
        .msg_pe(msg_pe), .ffi_wr(ffi_wr), .ffi_ready(ffi_ready),
        .ffi_val(ffi_val), .ffi_lock(ffi_lock), .ent_req(ent_req),
        .ent_idx(ent_idx), .ent_ack(ent_ack), .ent_pe(ent_pe),
        .trig_valid(trig_valid), .trig_src(trig_src), .trig_num(trig_num),
        .err_oob(err_oob), .err_pe(err_pe)
    );

    function automatic logic [7:0] table_pe(input logic [15:0] idx);
        return idx[7:0] ^ 8'h5A;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Entry memory model: acknowledges after two waiting cycles.
    initial begin
        int wait_n = 0;
        forever begin
            @(negedge clk);
            if (ent_req && !ent_ack) begin
                wait_n++;
                if (wait_n == 2) begin
                    ent_pe  = table_pe(ent_idx);
                    ent_ack = 1;
                    acks++;
                    wait_n  = 0;
                end
            end else begin
                ent_ack = 0;
            end
        end
    end

    // Scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && (trig_valid || err_oob || err_pe)) begin
                int kind;
                kind = trig_valid ? 0 : (err_oob ? 1 : 2);
                check("R11 single outcome", int'(trig_valid) + int'(err_oob) + int'(err_pe), 1);
                if (sb.size() == 0) begin
                    check("R11 unexpected outcome", kind, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R11 outcome kind (R3/R7)", kind, e.kind);
                    if (e.kind == 0) begin
                        check("R2 trig_src", int'(trig_src), e.src);
                        check("R2 trig_num", int'(trig_num), e.num);
                    end
                end
            end
        end
    end

    task automatic configure(input int base, input int cnt);
        @(negedge clk);
        cfg_wr = 1; cfg_base = 20'(base); cfg_count = 16'(cnt);
        @(negedge clk);
        cfg_wr = 0;
        base_m = base;
        cnt_m  = (cnt > 2048) ? 2048 : cnt;
    endtask

    function automatic exp_t predict(input logic [31:0] a, input logic [15:0] d,
                                     input bit pv, input logic [7:0] pe);
        exp_t e;
        int s;
        s = int'(((a >> 4) & 32'hFFFF) | (d & 16'h1F));
        e.src = s;
        e.num = (base_m + s) & 32'hFFFFF;
        if (s >= cnt_m) e.kind = 1;
        else if (pv && pe != table_pe(16'(s))) e.kind = 2;
        else e.kind = 0;
        return e;
    endfunction

    task automatic drain();
        int guard = 0;
        while ((sb.size() != 0 || !msg_ready) && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        check("R11 outcome drained", sb.size(), 0);
    endtask

    task automatic send_msg(input logic [31:0] a, input logic [15:0] d,
                            input bit pv, input logic [7:0] pe);
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        sb.push_back(predict(a, d, pv, pe));
        msg_valid = 1; msg_addr = a; msg_data = d; msg_pe_vld = pv; msg_pe = pe;
        @(posedge clk);
        #1;
        msg_valid = 0;
        check("R8 ready low after accept", int'(msg_ready), 0);
        drain();
    endtask

    task automatic send_ffi(input logic [31:0] v);
        @(negedge clk);
        while (!ffi_ready) @(negedge clk);
        sb.push_back(predict(v, 16'h0, 1'b0, 8'h0));
        ffi_wr = 1; ffi_val = v;
        @(posedge clk);
        #1;
        ffi_wr = 0;
        check("R9 lock set on accept", int'(ffi_lock), 1);
        drain();
        check("R9 lock cleared after outcome", int'(ffi_lock), 0);
    endtask

    initial begin
        #(4 * 100000);
        check("watchdog expired", 1, 0);
        if (!done_flag) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int acks0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 msg_ready reset", int'(msg_ready), 1);
        check("R1 ffi_ready reset", int'(ffi_ready), 1);
        check("R1 ffi_lock reset", int'(ffi_lock), 0);
        check("R1 no outcome reset", int'(trig_valid | err_oob | err_pe), 0);
        rst_n = 1;

        // R1: count 0 after reset, so everything is out of bounds
        send_msg(32'h0000_0010, 16'h0000, 1'b0, 8'h0);

        configure(32'h100, 64);
        acks0 = acks;
        // R2, R5: OR of fields, no PE
        send_msg(32'h0000_0120, 16'h0005, 1'b0, 8'h0);
        send_msg(32'h0000_0100, 16'h000F, 1'b0, 8'h0);
        send_msg(32'h0000_0200, 16'hFFE3, 1'b0, 8'h0);
        check("R5 no entry read without PE", acks - acks0, 0);

        // R3: boundary
        send_msg(32'h0000_03F0, 16'h0000, 1'b0, 8'h0);
        send_msg(32'h0000_0400, 16'h0000, 1'b0, 8'h0);
        acks0 = acks;
        send_msg(32'h0000_0400, 16'h0000, 1'b1, 8'h00);
        check("R3 no entry read when out of bounds", acks - acks0, 0);

        // R6, R7: PE match and mismatch
        acks0 = acks;
        send_msg(32'h0000_0120, 16'h0000, 1'b1, 8'h48);
        send_msg(32'h0000_0120, 16'h0000, 1'b1, 8'h00);
        send_msg(32'h0000_0000, 16'h001E, 1'b1, 8'h44);
        check("R6 entry reads issued", acks - acks0, 3);

        // R4: clamp
        configure(32'h0, 4000);
        send_msg(32'h0000_7FF0, 16'h0000, 1'b0, 8'h0);
        send_msg(32'h0000_8000, 16'h0000, 1'b0, 8'h0);

        // R9: fixed-function writes
        configure(32'h40, 64);
        send_ffi(32'h0000_0150);
        send_ffi(32'h0000_FFF0);

        // R10: simultaneous fixed-function and message
        @(negedge clk);
        while (!ffi_ready) @(negedge clk);
        sb.push_back(predict(32'h0000_0070, 16'h0, 1'b0, 8'h0));
        sb.push_back(predict(32'h0000_0030, 16'h0001, 1'b0, 8'h0));
        ffi_wr = 1; ffi_val = 32'h0000_0070;
        msg_valid = 1; msg_addr = 32'h0000_0030; msg_data = 16'h0001; msg_pe_vld = 0;
        #1;
        check("R10 msg_ready low while ffi_wr", int'(msg_ready), 0);
        @(posedge clk);
        #1;
        ffi_wr = 0;
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        @(posedge clk);
        #1;
        msg_valid = 0;
        drain();

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule